// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block divides a stream of count events by ten. Its state is a five-stage twisted-ring (Johnson) shift register. That register walks through ten patterns, and each pattern is decoded into one line of a ten-bit one-hot output. A carry line is high for the first half of the cycle, so it rises when the count wraps from nine to zero. That rising edge can drive the step input of a following stage.

The step and inhibit inputs are asynchronous pins. They are sampled on a free-running system clock, and their edges are found by comparing each sample with the one before it. Two conditions advance the count:

- a rising edge on step while inhibit is low;
- a falling edge on inhibit while step is high.

If both conditions occur in the same sample, the count advances only once. The clear input forces the count to zero asynchronously and is released synchronously. Any illegal ring pattern returns to zero on the next count event.

Top module: `johnson_decade_counter`

## Requirements
- R1: While `clear_i` is high, `dec_o` equals 10'b00_0000_0001 (line 0 high) and `carry_o` is 1. This takes effect without waiting for a clock edge.
- R2: A rising edge on `step_i` while `inhibit_i` is low advances the count by exactly one.
- R3: A falling edge on `inhibit_i` while `step_i` is high advances the count by exactly one.
- R4: The count does not change on any of these: an edge on `step_i` while `inhibit_i` is high, a falling edge on `step_i`, a rising edge on `inhibit_i`, or a falling edge on `inhibit_i` while `step_i` is low.
- R5: From any legal state, exactly one bit of `dec_o` is high. Bit n is high when the count is n.
- R6: The count runs 0, 1, …, 9 and wraps to 0, so the high bit of `dec_o` rotates one place toward the MSB on each event.
- R7: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R8: If a rising edge on `step_i` and a falling edge on `inhibit_i` fall in the same sample, the count advances by one only.
- R9: While `clear_i` is high, edges on `step_i` are ignored. After `clear_i` is released, a `step_i` level that stayed high across the release causes no count.
- R10: When a count event occurs while the ring holds an illegal pattern, the count goes to 0. The next event then gives count 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running system clock that samples the step and inhibit pins |
| clear_i | input | 1 | Active-high clear; asynchronous assert, synchronous release |
| step_i | input | 1 | Count pulse; its rising edge counts when inhibit is low |
| inhibit_i | input | 1 | Active-high count inhibit; its falling edge counts when step is high |
| dec_o | output | 10 | One-hot decoded count, bit n high for count n |
| carry_o | output | 1 | High for counts 0 to 4; its rising edge marks the wrap to 0 |

## Verification
The hardest condition to reach is an illegal ring pattern. Clear and counting only ever visit the ten legal patterns, so no sequence on the ports can produce one. The bench therefore briefly forces the ring register to two illegal patterns. It then releases the register, which keeps the forced value, and applies ordinary step pulses at the ports. The one-hot output must come back as count 0 and then count 1. A second corner case is a step level held high across the release of clear, which must not count. The bench sets this up by raising step while clear is active.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;

   localparam int unsigned JDC_MAX_STAGES = 16;

   typedef logic [31:0] jdc_vec_t;

   // Count neighbouring-bit changes in the lowest n bits of v.
   // A legal Johnson pattern has at most one such change.
   function automatic int unsigned jdc_transitions(input jdc_vec_t v, input int unsigned n);
      int unsigned cnt;
      cnt = 0;
      for (int unsigned i = 0; i < 31; i++) begin
         if ((i + 1 < n) && (v[i] != v[i+1])) cnt++;
      end
      return cnt;
   endfunction

   function automatic logic jdc_is_legal(input jdc_vec_t v, input int unsigned n);
      return jdc_transitions(v, n) <= 1;
   endfunction

endpackage

// File: rtl/jdc_edge_sampler.sv
`timescale 1ns/1ps
module jdc_edge_sampler #(
   parameter int unsigned SYNC_DEPTH = 2
) (
   input  logic clk_i,
   input  logic step_i,
   input  logic inhibit_i,
   output logic step_lvl_o,
   output logic inhibit_lvl_o,
   output logic step_rise_o,
   output logic inhibit_fall_o
);

   logic [SYNC_DEPTH-1:0] step_sync_q;
   logic [SYNC_DEPTH-1:0] inh_sync_q;
   logic                  step_prev_q;
   logic                  inh_prev_q;

   generate
      if (SYNC_DEPTH < 1) begin : g_bad_depth
         $error("jdc_edge_sampler: SYNC_DEPTH must be at least 1");
      end
      if (SYNC_DEPTH == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            step_sync_q <= step_i;
            inh_sync_q  <= inhibit_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i) begin
            step_sync_q <= {step_sync_q[SYNC_DEPTH-2:0], step_i};
            inh_sync_q  <= {inh_sync_q[SYNC_DEPTH-2:0], inhibit_i};
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      step_prev_q <= step_sync_q[SYNC_DEPTH-1];
      inh_prev_q  <= inh_sync_q[SYNC_DEPTH-1];
   end

   assign step_lvl_o     = step_sync_q[SYNC_DEPTH-1];
   assign inhibit_lvl_o  = inh_sync_q[SYNC_DEPTH-1];
   assign step_rise_o    = step_lvl_o & ~step_prev_q;
   assign inhibit_fall_o = ~inhibit_lvl_o & inh_prev_q;

endmodule

// File: rtl/jdc_release_sync.sv
`timescale 1ns/1ps
module jdc_release_sync #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk_i,
   input  logic clear_i,
   output logic hold_o
);

   logic [DEPTH-1:0] hold_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("jdc_release_sync: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk_i or posedge clear_i) begin
            if (clear_i) hold_q <= 1'b1;
            else         hold_q <= 1'b0;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or posedge clear_i) begin
            if (clear_i) hold_q <= '1;
            else         hold_q <= {hold_q[DEPTH-2:0], 1'b0};
         end
      end
   endgenerate

   assign hold_o = hold_q[DEPTH-1];

endmodule

// File: rtl/jdc_ring.sv
`timescale 1ns/1ps
module jdc_ring
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = 5
) (
   input  logic              clk_i,
   input  logic              clear_i,
   input  logic              hold_i,
   input  logic              adv_i,
   output logic [STAGES-1:0] state_o
);

   localparam int unsigned PAD = 32 - STAGES;

   logic [STAGES-1:0] state_q;
   logic [STAGES-1:0] state_next;
   logic              legal;

   always_comb begin
      legal = jdc_is_legal({{PAD{1'b0}}, state_q}, STAGES);
      if (legal) state_next = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
      else       state_next = '0;
   end

   always_ff @(posedge clk_i or posedge clear_i) begin
      if (clear_i)     state_q <= '0;
      else if (hold_i) state_q <= '0;
      else if (adv_i)  state_q <= state_next;
   end

   assign state_o = state_q;

endmodule

// File: rtl/jdc_decoder.sv
`timescale 1ns/1ps
module jdc_decoder #(
   parameter int unsigned STAGES = 5
) (
   input  logic [STAGES-1:0]   state_i,
   output logic [2*STAGES-1:0] dec_o,
   output logic                carry_o
);

   localparam int unsigned DIVISOR = 2 * STAGES;

   // Each output looks at one pair of neighbouring ring bits.
   generate
      for (genvar k = 0; k < DIVISOR; k++) begin : g_line
         if (k == 0) begin : g_zero
            assign dec_o[k] = ~state_i[0] & ~state_i[STAGES-1];
         end else if (k < STAGES) begin : g_fill
            assign dec_o[k] = state_i[k-1] & ~state_i[k];
         end else if (k == STAGES) begin : g_full
            assign dec_o[k] = state_i[0] & state_i[STAGES-1];
         end else begin : g_drain
            assign dec_o[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
         end
      end
   endgenerate

   assign carry_o = ~state_i[STAGES-1];

endmodule

// File: rtl/johnson_decade_counter.sv
`timescale 1ns/1ps
module johnson_decade_counter
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES        = 5,
   parameter int unsigned SYNC_DEPTH    = 2,
   parameter int unsigned RELEASE_DEPTH = 2
) (
   input  logic                clk_i,
   input  logic                clear_i,
   input  logic                step_i,
   input  logic                inhibit_i,
   output logic [2*STAGES-1:0] dec_o,
   output logic                carry_o
);

   localparam int unsigned DIVISOR = 2 * STAGES;

   generate
      if (STAGES < 2 || STAGES > JDC_MAX_STAGES) begin : g_bad_stages
         $error("johnson_decade_counter: STAGES out of range");
      end
   endgenerate

   logic              step_lvl;
   logic              inhibit_lvl;
   logic              step_rise;
   logic              inhibit_fall;
   logic              hold;
   logic              count_evt;
   logic [STAGES-1:0] ring_state;

   jdc_edge_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_sampler (
      .clk_i          (clk_i),
      .step_i         (step_i),
      .inhibit_i      (inhibit_i),
      .step_lvl_o     (step_lvl),
      .inhibit_lvl_o  (inhibit_lvl),
      .step_rise_o    (step_rise),
      .inhibit_fall_o (inhibit_fall)
   );

   jdc_release_sync #(.DEPTH(RELEASE_DEPTH)) u_release (
      .clk_i   (clk_i),
      .clear_i (clear_i),
      .hold_o  (hold)
   );

   // Either edge condition counts; both together count once.
   assign count_evt = ~hold & ((step_rise & ~inhibit_lvl) | (inhibit_fall & step_lvl));

   jdc_ring #(.STAGES(STAGES)) u_ring (
      .clk_i   (clk_i),
      .clear_i (clear_i),
      .hold_i  (hold),
      .adv_i   (count_evt),
      .state_o (ring_state)
   );

   jdc_decoder #(.STAGES(STAGES)) u_dec (
      .state_i (ring_state),
      .dec_o   (dec_o),
      .carry_o (carry_o)
   );

   logic unused_div;
   assign unused_div = (DIVISOR == 0);

endmodule

// File: rtl/jdc_checker.sv
`timescale 1ns/1ps
module jdc_checker
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = 5
) (
   input logic                clk_i,
   input logic                clear_i,
   input logic                adv,
   input logic [STAGES-1:0]   state,
   input logic [2*STAGES-1:0] dec,
   input logic                carry
);

   localparam int unsigned DIVISOR = 2 * STAGES;
   localparam int unsigned PAD     = 32 - STAGES;

   logic legal_now;
   assign legal_now = jdc_is_legal({{PAD{1'b0}}, state}, STAGES);

   AST_CLEAR_ZERO: assert property (@(posedge clk_i)
      clear_i |-> (dec == DIVISOR'(1)) && carry); // R1

   AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (clear_i)
      legal_now |-> $onehot(dec)); // R5

   AST_ROTATE: assert property (@(posedge clk_i) disable iff (clear_i)
      (adv && legal_now) |=> dec == {$past(dec[DIVISOR-2:0]), $past(dec[DIVISOR-1])}); // R6

   AST_CARRY_HALF: assert property (@(posedge clk_i) disable iff (clear_i)
      legal_now |-> (carry == (dec[STAGES-1:0] != '0))); // R7

   AST_RECOVER: assert property (@(posedge clk_i) disable iff (clear_i)
      (adv && !legal_now) |=> dec == DIVISOR'(1)); // R10

endmodule

bind johnson_decade_counter jdc_checker #(.STAGES(STAGES)) u_jdc_checker (
   .clk_i   (clk_i),
   .clear_i (clear_i),
   .adv     (count_evt),
   .state   (ring_state),
   .dec     (dec_o),
   .carry   (carry_o)
);

// File: tb/johnson_decade_counter_bench.sv
`timescale 1ns/1ps
module johnson_decade_counter_bench;

   logic       clk = 1'b0;
   logic       clear_i;
   logic       step_i;
   logic       inhibit_i;
   logic [9:0] dec_o;
   logic       carry_o;

   int tests_run = 0;
   int tests_failed = 0;
   int cnt = 0;

   always #2 clk = ~clk;

   johnson_decade_counter u_johnson_decade_counter (
      .clk_i     (clk),
      .clear_i   (clear_i),
      .step_i    (step_i),
      .inhibit_i (inhibit_i),
      .dec_o     (dec_o),
      .carry_o   (carry_o)
   );

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic check(input string req, input int exp_n);
      logic [9:0] exp_dec;
      logic       exp_carry;
      exp_dec   = 10'(1) << exp_n;
      exp_carry = (exp_n < 5);
      tests_run++;
      if (dec_o !== exp_dec || carry_o !== exp_carry) begin
         tests_failed++;
         $display("FAIL %s: dec=%b carry=%b expected dec=%b carry=%b",
                  req, dec_o, carry_o, exp_dec, exp_carry);
      end
   endtask

   task automatic pulse_step();
      step_i = 1'b1; settle();
      step_i = 1'b0; settle();
   endtask

   task automatic t_reset();
      clear_i = 1'b1; step_i = 1'b0; inhibit_i = 1'b0;
      repeat (3) @(negedge clk);
      cnt = 0;
      check("R1 clear state", cnt);
      clear_i = 1'b0; settle();
      check("R1 after release", cnt);
   endtask

   task automatic t_step_sequence();
      for (int i = 0; i < 12; i++) begin
         pulse_step();
         cnt = (cnt + 1) % 10;
         check("R2 R5 R6 R7 step sequence", cnt);
      end
   endtask

   task automatic t_inhibit_clock();
      inhibit_i = 1'b1; settle();
      check("R4 inhibit rise", cnt);
      step_i = 1'b1; settle();
      check("R4 step rise inhibited", cnt);
      inhibit_i = 1'b0; settle();
      cnt = (cnt + 1) % 10;
      check("R3 inhibit fall with step high", cnt);
      inhibit_i = 1'b1; settle();
      check("R4 inhibit rise with step high", cnt);
      step_i = 1'b0; settle();
      check("R4 step fall inhibited", cnt);
      inhibit_i = 1'b0; settle();
      check("R4 inhibit fall with step low", cnt);
   endtask

   task automatic t_ignored();
      inhibit_i = 1'b1;
      for (int i = 0; i < 3; i++) pulse_step();
      check("R4 step pulses while inhibited", cnt);
      inhibit_i = 1'b0; settle();
      step_i = 1'b1; settle();
      cnt = (cnt + 1) % 10;
      check("R2 step rise", cnt);
      step_i = 1'b0; settle();
      check("R4 step fall", cnt);
   endtask

   task automatic t_simultaneous();
      inhibit_i = 1'b1; step_i = 1'b0; settle();
      @(negedge clk);
      step_i = 1'b1; inhibit_i = 1'b0;
      settle();
      cnt = (cnt + 1) % 10;
      check("R8 coincident edges count once", cnt);
      step_i = 1'b0; settle();
      check("R8 no extra count", cnt);
   endtask

   task automatic t_clear_override();
      pulse_step(); cnt = (cnt + 1) % 10;
      pulse_step(); cnt = (cnt + 1) % 10;
      @(negedge clk);
      clear_i = 1'b1;
      #0.5;
      cnt = 0;
      check("R1 asynchronous clear", cnt);
      for (int i = 0; i < 3; i++) pulse_step();
      check("R9 steps ignored during clear", cnt);
      step_i = 1'b1; settle();
      @(negedge clk);
      clear_i = 1'b0;
      repeat (8) @(negedge clk);
      check("R9 held step across release", cnt);
      step_i = 1'b0; settle();
      check("R9 step fall after release", cnt);
      pulse_step(); cnt = (cnt + 1) % 10;
      check("R9 counting resumes", cnt);
   endtask

   task automatic t_recover(input logic [4:0] bad);
      @(negedge clk);
      force u_johnson_decade_counter.u_ring.state_q = bad;
      #0.5;
      release u_johnson_decade_counter.u_ring.state_q;
      settle();
      pulse_step();
      cnt = 0;
      check("R10 illegal pattern returns to zero", cnt);
      pulse_step();
      cnt = 1;
      check("R10 normal count after recovery", cnt);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_step_sequence();
      t_inhibit_clock();
      t_ignored();
      t_simultaneous();
      t_clear_override();
      t_recover(5'b00101);
      t_recover(5'b01011);
      finish_run();
   end

endmodule